// File: doc/BRIEF.md
# Configurable Logic Cell Tile

A programmable logic tile of eight identical cells. Every cell holds a 4-input lookup table, an optional carry stage and an optional flip-flop. The truth table and the per-cell sequential mode arrive as static configuration ports. The tile's cells read one shared clock, clock enable and set/reset input. A tile-wide bit picks which clock edge the flip-flops use.

The carry runs upward from cell 0 to the last cell. Cell 0 reads the tile carry input only when the cascade bit is set. The last cell's carry leaves the tile on its own port, so tiles can be stacked into longer arithmetic chains. A cell in combinational mode shows its lookup result directly. In that mode its flip-flop holds state without affecting the output.

Top module: `lut_tile`

## Requirements
- R1: With its registered bit clear, cell c drives `cell_out[c]` combinationally with bit `{in3,in2,in1,in0}` of its 16-bit table `lut_cfg[c*16 +: 16]`, where in0 is `cell_in[c*4]` and in3 is `cell_in[c*4+3]`.
- R2: Each cell's 4-bit mode field `seq_cfg[c*4 +: 4]` holds carry enable at bit 0, registered output at bit 1, the set/reset load value at bit 2 and asynchronous set/reset (1) versus synchronous (0) at bit 3.
- R3: A cell with carry enabled produces a carry-out equal to the majority of its in1, its in2 and its carry-in; with carry disabled its carry-out is 0.
- R4: Cell 0's carry-in equals `carry_in` when `cascade_en` is 1 and 0 otherwise; each higher cell takes the carry-out of the cell below; `carry_out` is the last cell's carry-out.
- R5: In synchronous mode, at an active edge with `clk_en` high, the flip-flop loads the set/reset value when `set_reset` is high and the lookup result otherwise; a `set_reset` that rises between edges changes nothing until the edge.
- R6: In asynchronous mode, a high `set_reset` forces the flip-flop to its set/reset value at once, whatever the clock and `clk_en`.
- R7: With `clk_en` low, a flip-flop in synchronous mode keeps its value across active edges, even with `set_reset` high.
- R8: With `neg_clk` at 1, all flip-flops capture on the falling edge of `clk` and ignore the rising edge; with 0 they capture on the rising edge.
- R9: Clearing the registered bit makes the output follow the lookup result without disturbing the flip-flop; setting the bit again shows the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tile clock |
| clk_en | input | 1 | Shared flip-flop clock enable |
| set_reset | input | 1 | Shared set/reset, active high |
| neg_clk | input | 1 | 1 selects the falling edge as active; change it only while `clk` is low when clearing and high when setting |
| cascade_en | input | 1 | Passes `carry_in` into cell 0 |
| carry_in | input | 1 | Carry from the tile below |
| lut_cfg | input | 128 | Truth tables, 16 bits per cell |
| seq_cfg | input | 32 | Mode fields, 4 bits per cell |
| cell_in | input | 32 | Lookup inputs, 4 per cell, in0 lowest |
| cell_out | output | 8 | Cell outputs |
| carry_out | output | 1 | Carry-out of the last cell |

## Verification
A wrong flip-flop value shows at `cell_out` right after the active edge that loaded it, if the cell is registered. In combinational mode the flip-flop stays hidden until the registered bit is set again. A broken carry link is seen only through `carry_out`, and only when every cell above the fault propagates. The carry tests therefore put generate, kill and disabled cells at chosen positions under an otherwise propagating chain.

// File: rtl/lut_tile_pkg.sv
package lut_tile_pkg;

   localparam int SEQ_CFG_W = 4;

   // per-cell mode field, bit 0 at the bottom
   typedef struct packed {
      logic sr_async;   // bit 3
      logic sr_val;     // bit 2
      logic reg_out;    // bit 1
      logic carry_en;   // bit 0
   } seq_cfg_t;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | ((a | b) & c);
   endfunction

endpackage

// File: rtl/lut_tile_lut.sv
module lut_tile_lut #(
   parameter int K = 4
) (
   input  logic [(1<<K)-1:0] tt_bits,
   input  logic [K-1:0]      sel,
   output logic              y
);
   localparam int LEAVES = 1 << K;

   // heap-ordered mux tree: node n has children 2n and 2n+1
   logic [2*LEAVES-1:1] node;

   assign node[2*LEAVES-1:LEAVES] = tt_bits;

   for (genvar n = 1; n < LEAVES; n++) begin : g_node
      localparam int DEPTH = $clog2(n + 1) - 1;
      assign node[n] = sel[K-1-DEPTH] ? node[2*n+1] : node[2*n];
   end

   assign y = node[1];
endmodule

// File: rtl/lut_tile_carry.sv
module lut_tile_carry
   import lut_tile_pkg::*;
(
   input  logic en,
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic co
);
   assign co = en & maj3(a, b, ci);
endmodule

// File: rtl/lut_tile_ff.sv
module lut_tile_ff (
   input  logic clk_act,
   input  logic cen,
   input  logic sr,
   input  logic async_en,
   input  logic sr_val,
   input  logic d,
   output logic q
);
   logic arst;

   assign arst = sr & async_en;

   always_ff @(posedge clk_act or posedge arst) begin
      if (arst)
         q <= sr_val;
      else if (cen)
         q <= sr ? sr_val : d;
   end
endmodule

// File: rtl/lut_tile.sv
module lut_tile
   import lut_tile_pkg::*;
#(
   parameter int NUM_CELLS       = 8,
   parameter int LUT_K           = 4,
   parameter bit NEG_CLK_SUPPORT = 1'b1
) (
   input  logic                              clk,
   input  logic                              clk_en,
   input  logic                              set_reset,
   input  logic                              neg_clk,
   input  logic                              cascade_en,
   input  logic                              carry_in,
   input  logic [NUM_CELLS*(1<<LUT_K)-1:0]   lut_cfg,
   input  logic [NUM_CELLS*SEQ_CFG_W-1:0]    seq_cfg,
   input  logic [NUM_CELLS*LUT_K-1:0]        cell_in,
   output logic [NUM_CELLS-1:0]              cell_out,
   output logic                              carry_out
);
   localparam int LUT_BITS = 1 << LUT_K;

   if (NUM_CELLS < 1) begin : g_bad_cells
      $error("lut_tile: NUM_CELLS must be at least 1");
   end
   if (LUT_K < 3 || LUT_K > 6) begin : g_bad_k
      $error("lut_tile: LUT_K must lie in 3..6");
   end

   logic clk_act;

   if (NEG_CLK_SUPPORT) begin : g_clk_pol
      // XOR with the static polarity bit; falling edge of clk becomes the rising edge here
      assign clk_act = clk ^ neg_clk;
   end else begin : g_clk_fixed
      assign clk_act = clk;
   end

   logic [NUM_CELLS:0] cy;

   assign cy[0]     = cascade_en & carry_in;
   assign carry_out = cy[NUM_CELLS];

   for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
      seq_cfg_t mode;
      logic     lut_y;
      logic     ff_q;

      assign mode = seq_cfg_t'(seq_cfg[c*SEQ_CFG_W +: SEQ_CFG_W]);

      lut_tile_lut #(.K(LUT_K)) lut_i (
         .tt_bits (lut_cfg[c*LUT_BITS +: LUT_BITS]),
         .sel     (cell_in[c*LUT_K +: LUT_K]),
         .y       (lut_y)
      );

      lut_tile_carry carry_i (
         .en (mode.carry_en),
         .a  (cell_in[c*LUT_K + 1]),
         .b  (cell_in[c*LUT_K + 2]),
         .ci (cy[c]),
         .co (cy[c+1])
      );

      lut_tile_ff ff_i (
         .clk_act  (clk_act),
         .cen      (clk_en),
         .sr       (set_reset),
         .async_en (mode.sr_async),
         .sr_val   (mode.sr_val),
         .d        (lut_y),
         .q        (ff_q)
      );

      assign cell_out[c] = mode.reg_out ? ff_q : lut_y;
   end
endmodule

// File: rtl/lut_tile_chk.sv
module lut_tile_chk #(
   parameter int NUM_CELLS = 8,
   parameter int LUT_K     = 4
) (
   input logic                              clk,
   input logic                              clk_en,
   input logic                              set_reset,
   input logic                              neg_clk,
   input logic [NUM_CELLS*(1<<LUT_K)-1:0]   lut_cfg,
   input logic [NUM_CELLS*4-1:0]            seq_cfg,
   input logic [NUM_CELLS*LUT_K-1:0]        cell_in,
   input logic [NUM_CELLS-1:0]              cell_out,
   input logic                              carry_out
);
   localparam int LB = 1 << LUT_K;

   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= 1'b1;

   // R3: disabled carry in the last cell leaves nothing on carry_out
   a_r3_carry_off: assert property (@(posedge clk) disable iff (!armed)
      !seq_cfg[(NUM_CELLS-1)*4] |-> !carry_out);

   for (genvar c = 0; c < NUM_CELLS; c++) begin : g_chk
      logic [LB-1:0]    tbl;
      logic [LUT_K-1:0] idx;
      logic             regm, srv, asy;

      assign tbl  = lut_cfg[c*LB +: LB];
      assign idx  = cell_in[c*LUT_K +: LUT_K];
      assign regm = seq_cfg[c*4 + 1];
      assign srv  = seq_cfg[c*4 + 2];
      assign asy  = seq_cfg[c*4 + 3];

      // R1: combinational cell shows the indexed table bit
      a_r1_comb_lut: assert property (@(posedge clk) disable iff (!armed)
         !regm |-> (cell_out[c] == tbl[idx]));

      // R6: asynchronous set/reset holds the output at the load value
      a_r6_async_force: assert property (@(posedge clk) disable iff (!armed)
         (set_reset && asy && regm) |-> (cell_out[c] == srv));

      // R5: synchronous set/reset with enable loads the value at the edge
      a_r5_sync_load: assert property (@(posedge clk) disable iff (!armed)
         (!neg_clk && clk_en && set_reset && regm && !asy) |=>
         (!$stable(seq_cfg) || !$stable(neg_clk) || cell_out[c] == srv));

      // R7: enable low keeps a registered output steady
      a_r7_hold: assert property (@(posedge clk) disable iff (!armed)
         (!neg_clk && !clk_en && !set_reset && regm) |=>
         (!$stable(seq_cfg) || !$stable(neg_clk) || set_reset || $stable(cell_out[c])));
   end
endmodule

bind lut_tile lut_tile_chk #(.NUM_CELLS(NUM_CELLS), .LUT_K(LUT_K)) chk_i (
   .clk       (clk),
   .clk_en    (clk_en),
   .set_reset (set_reset),
   .neg_clk   (neg_clk),
   .lut_cfg   (lut_cfg),
   .seq_cfg   (seq_cfg),
   .cell_in   (cell_in),
   .cell_out  (cell_out),
   .carry_out (carry_out)
);

// File: tb/lut_tile_tb.sv
`timescale 1ns/1ps
module lut_tile_tb_top;
   localparam int N  = 8;
   localparam int K  = 4;
   localparam int LB = 16;

   logic             clk = 1'b0;
   logic             clk_en = 1'b1;
   logic             set_reset = 1'b0;
   logic             neg_clk = 1'b0;
   logic             cascade_en = 1'b0;
   logic             carry_in = 1'b0;
   logic [N*LB-1:0]  lut_cfg = '0;
   logic [N*4-1:0]   seq_cfg = '0;
   logic [N*K-1:0]   cell_in = '0;
   logic [N-1:0]     cell_out;
   logic             carry_out;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   lut_tile dut_i (
      .clk(clk), .clk_en(clk_en), .set_reset(set_reset), .neg_clk(neg_clk),
      .cascade_en(cascade_en), .carry_in(carry_in), .lut_cfg(lut_cfg),
      .seq_cfg(seq_cfg), .cell_in(cell_in), .cell_out(cell_out),
      .carry_out(carry_out)
   );

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // mode field per cell: bit0 carry, bit1 registered, bit2 load value, bit3 async
   function automatic logic [N*4-1:0] mk_seq(input logic [N-1:0] cy, input logic [N-1:0] rg,
                                             input logic [N-1:0] sv, input logic [N-1:0] as);
      logic [N*4-1:0] s;
      for (int c = 0; c < N; c++) s[c*4 +: 4] = {as[c], sv[c], rg[c], cy[c]};
      return s;
   endfunction

   // drive only in0 of every cell
   task automatic set_in0(input logic [N-1:0] d);
      cell_in = '0;
      for (int c = 0; c < N; c++) cell_in[c*K] = d[c];
   endtask

   task automatic all_tables(input logic [LB-1:0] t);
      for (int c = 0; c < N; c++) lut_cfg[c*LB +: LB] = t;
   endtask

   // move to 1 ns after the next rising edge
   task automatic tick();
      @(posedge clk); #1;
   endtask

   function automatic logic carry_ref(input logic [N-1:0] en, input logic [N-1:0] a,
                                      input logic [N-1:0] b, input logic cas, input logic ci);
      logic c0 = cas & ci;
      for (int c = 0; c < N; c++) c0 = en[c] & ((a[c] & b[c]) | ((a[c] | b[c]) & c0));
      return c0;
   endfunction

   task automatic test_reset_state();
      // R6: asynchronous load gives the power-up pattern
      seq_cfg = mk_seq('0, '1, 8'h55, '1);
      #2 set_reset = 1'b1;
      #1 check("R6 reset state", cell_out, 8'h55);
      tick();
      set_reset = 1'b0;
   endtask

   task automatic test_lut();
      logic [LB-1:0] t [N];
      logic [N-1:0]  e;
      t[0] = 16'h8000; t[1] = 16'h6996; t[2] = 16'hFFFE; t[3] = 16'h0001;
      t[4] = 16'hAAAA; t[5] = 16'hCCCC; t[6] = 16'hF0F0; t[7] = 16'hFF00;
      for (int c = 0; c < N; c++) lut_cfg[c*LB +: LB] = t[c];
      seq_cfg = mk_seq('0, '0, '0, '0);
      for (int i = 0; i < 16; i++) begin
         for (int c = 0; c < N; c++) begin
            cell_in[c*K +: K] = 4'(i);
            e[c] = t[c][i];
         end
         #0.5 check($sformatf("R1 R2 lut index %0d", i), cell_out, e);
      end
   endtask

   task automatic carry_case(input string tag, input logic [N-1:0] en, input logic [N-1:0] a,
                             input logic [N-1:0] b, input logic cas, input logic ci);
      seq_cfg = mk_seq(en, '0, '0, '0);
      cascade_en = cas; carry_in = ci;
      cell_in = '0;
      for (int c = 0; c < N; c++) begin
         cell_in[c*K+1] = a[c];
         cell_in[c*K+2] = b[c];
      end
      #0.5 check(tag, {7'd0, carry_out}, {7'd0, carry_ref(en, a, b, cas, ci)});
   endtask

   task automatic test_carry();
      all_tables(16'h0000);
      carry_case("R3 R4 propagate with cascade", '1, '1, '0, 1'b1, 1'b1);
      carry_case("R4 cascade off blocks carry_in", '1, '1, '0, 1'b0, 1'b1);
      carry_case("R4 carry_in low", '1, '0, '1, 1'b1, 1'b0);
      carry_case("R3 generate at cell 2", '1, 8'hFF, 8'h04, 1'b0, 1'b0);
      carry_case("R3 kill at cell 5", '1, 8'hDF, 8'h04, 1'b0, 1'b0);
      carry_case("R3 disabled cell 3 breaks chain", 8'hF7, '1, '0, 1'b1, 1'b1);
      carry_case("R3 R2 last cell carry off", 8'h7F, '1, '1, 1'b1, 1'b1);
      cascade_en = 1'b0; carry_in = 1'b0;
   endtask

   task automatic test_sync();
      all_tables(16'hAAAA);
      seq_cfg = mk_seq('0, '1, 8'hAA, '0);
      clk_en = 1'b1; set_reset = 1'b0;
      set_in0(8'h3C);
      tick();
      check("R5 sync load lookup", cell_out, 8'h3C);
      set_in0(8'hC3); set_reset = 1'b1;
      #1 check("R5 sync reset waits for edge", cell_out, 8'h3C);
      tick();
      check("R5 sync load set/reset value", cell_out, 8'hAA);
      set_reset = 1'b0;
      tick();
      check("R5 sync load after release", cell_out, 8'hC3);
   endtask

   task automatic test_enable();
      set_in0(8'h5A);
      clk_en = 1'b0;
      tick();
      check("R7 hold with enable low", cell_out, 8'hC3);
      set_reset = 1'b1;
      tick();
      check("R7 sync set/reset ignored with enable low", cell_out, 8'hC3);
      set_reset = 1'b0;
      clk_en = 1'b1;
      tick();
      check("R7 load after enable returns", cell_out, 8'h5A);
   endtask

   task automatic test_async();
      seq_cfg = mk_seq('0, '1, 8'h0F, '1);
      clk_en = 1'b0;
      set_reset = 1'b1;
      #1 check("R6 async force between edges", cell_out, 8'h0F);
      tick();
      check("R6 async force holds", cell_out, 8'h0F);
      set_reset = 1'b0;
      clk_en = 1'b1;
      set_in0(8'h99);
      tick();
      check("R6 load after async release", cell_out, 8'h99);
   endtask

   task automatic test_negclk();
      seq_cfg = mk_seq('0, '1, '0, '0);
      set_in0(8'h11);
      tick();
      check("R8 rising edge load", cell_out, 8'h11);
      neg_clk = 1'b1;
      set_in0(8'h22);
      #0.5 check("R8 no capture before falling edge", cell_out, 8'h11);
      @(negedge clk); #1;
      check("R8 falling edge capture", cell_out, 8'h22);
      set_in0(8'h44);
      tick();
      check("R8 rising edge ignored", cell_out, 8'h22);
      @(negedge clk); #1;
      check("R8 second falling edge capture", cell_out, 8'h44);
      neg_clk = 1'b0;
      tick();
   endtask

   task automatic test_bypass();
      seq_cfg = mk_seq('0, '1, '0, '0);
      set_in0(8'h81);
      tick();
      clk_en = 1'b0;
      set_in0(8'h7E);
      seq_cfg = mk_seq('0, '0, '0, '0);
      #0.5 check("R9 bypass shows lookup", cell_out, 8'h7E);
      tick();
      seq_cfg = mk_seq('0, '1, '0, '0);
      #0.5 check("R9 held value returns", cell_out, 8'h81);
      clk_en = 1'b1;
   endtask

   initial begin
      test_reset_state();
      test_lut();
      test_carry();
      test_sync();
      test_enable();
      test_async();
      test_negclk();
      test_bypass();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule